// File: doc/BRIEF.md
# FIFO with Programmable Level Flags

A single-clock first-in first-out buffer that reports its fill level as a set of separate flags: empty, not-empty, full, not-full, almost-empty and almost-full. Software-style configuration inputs load two offset registers and a select bit. When the select bit is clear, the almost thresholds sit at fixed quarter-depth points. When it is set, the offsets move those thresholds, and an offset of zero turns the matching almost flag off.

Pushing into a full buffer and popping from an empty one are errors. Each error sets a sticky bit in the status vector. The bit stays set until a clear-error pulse arrives. A push and a pop in the same cycle always succeed, even on a full or an empty buffer, so a streaming producer and consumer never raise a false error at the edges.

Top module: `prog_flag_fifo`

## Requirements
- R1: After reset the buffer holds no words. The status reads empty and not-full. With the default thresholds almost-empty is also set. Every other status bit is clear, and pop_valid is low.
- R2: Words leave in the order they entered. pop_valid and pop_data appear in the cycle after the accepted pop.
- R3: Status bit positions are: bit0 empty (count 0), bit1 not-empty, bit2 full (count equals DEPTH), bit3 not-full, bit4 almost-empty, bit5 almost-full, bit6 overrun, bit7 underrun.
- R4: With the select bit clear, almost-empty is set while count < DEPTH/4. Almost-full is set while count > DEPTH - DEPTH/4.
- R5: With the select bit set, almost-empty is set while count < empty-offset. Almost-full is set while count > DEPTH - full-offset. This moves the trip points away from the defaults.
- R6: With the select bit set and both offsets zero, neither almost flag is ever set, at any fill level.
- R7: A push without a pop on a full buffer drops the word, leaves the contents unchanged and sets the sticky overrun bit.
- R8: A pop without a push on an empty buffer gives no valid data (pop_valid stays low) and sets the sticky underrun bit.
- R9: Overrun and underrun stay set until err_clr is pulsed, and that pulse clears both. If a new error occurs in the same cycle as err_clr, that error's bit is set.
- R10: A push and pop together on a full buffer raise no error. The oldest word is returned and the buffer stays full.
- R11: A push and pop together on an empty buffer raise no error. The pushed word is returned in the next cycle and the buffer stays empty.
- R12: The offsets and the select bit change only on a cycle with cfg_wr high. Changing the cfg inputs without that strobe does not change the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Push strobe |
| push_data | input | WIDTH | Word to push |
| pop | input | 1 | Pop strobe |
| pop_data | output | WIDTH | Word popped, valid with pop_valid |
| pop_valid | output | 1 | Pop returned a word (one cycle after pop) |
| cfg_wr | input | 1 | Load offsets and select bit |
| cfg_use_off | input | 1 | Select bit: 1 uses the offsets for the almost flags |
| cfg_af_off | input | log2(DEPTH) | Almost-full offset |
| cfg_ae_off | input | log2(DEPTH) | Almost-empty offset |
| err_clr | input | 1 | Clear overrun and underrun |
| status | output | 8 | Flag vector, layout per R3 |

## Verification
A short mixed push/pop table runs through the quarter-depth region. It separates correct ordering from a pointer slip, and it exercises pass-through on empty. Full fills and drains are run three times: with the default thresholds, with non-default offsets (empty 6, full 2), and with zero offsets. Together these runs show whether the select bit actually reroutes the thresholds and whether a zero offset disables its flag. The corner patterns are push-on-full, pop-on-empty, push with pop at both limits, and clear colliding with a new error. They separate data being dropped from data being corrupted, and sticky behaviour from level behaviour.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    // Status layout, LSB first: empty, not_empty, full, not_full, ae, af, ovr, udr
    typedef struct packed {
        logic udr;
        logic ovr;
        logic af;
        logic ae;
        logic not_full;
        logic full;
        logic not_empty;
        logic empty;
    } fifo_status_t;

    typedef struct packed {
        logic wr_en;
        logic rd_en;
        logic bypass;
        logic ovr_evt;
        logic udr_evt;
    } fifo_op_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_BOTH  = 2'b11
    } op_kind_e;

    // Resolve the strobes against the current level
    function automatic fifo_op_t resolve_op(input logic push, input logic pop,
                                            input logic is_full, input logic is_empty);
        fifo_op_t o;
        op_kind_e k;
        o = '0;
        k = op_kind_e'({pop, push});
        case (k)
            OP_WRITE: begin
                o.wr_en   = !is_full;
                o.ovr_evt = is_full;
            end
            OP_READ: begin
                o.rd_en   = !is_empty;
                o.udr_evt = is_empty;
            end
            OP_BOTH: begin
                o.wr_en  = 1'b1;
                o.rd_en  = 1'b1;
                o.bypass = is_empty;
            end
            default: o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/fifo_track.sv
module fifo_track
    import fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic                       pop,
    output logic                       wr_en,
    output logic                       rd_en,
    output logic                       bypass,
    output logic                       ovr_evt,
    output logic                       udr_evt,
    output logic [$clog2(DEPTH)-1:0]   wr_ptr,
    output logic [$clog2(DEPTH)-1:0]   rd_ptr,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    fifo_op_t op;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        op      = resolve_op(push, pop, count == CW'(DEPTH), count == '0);
        wr_en   = op.wr_en;
        rd_en   = op.rd_en;
        bypass  = op.bypass;
        ovr_evt = op.ovr_evt;
        udr_evt = op.udr_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (op.wr_en) wr_ptr <= bump(wr_ptr);
            if (op.rd_en) rd_ptr <= bump(rd_ptr);
            if (op.wr_en && !op.rd_en)      count <= count + 1'b1;
            else if (op.rd_en && !op.wr_en) count <= count - 1'b1;
        end
    end

    // R7: a lone push on a full buffer leaves it full
    assert_full_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH) && push && !pop) |=> (count == CW'(DEPTH)));
    // R10 / R11: simultaneous push and pop keep the level
    assert_both_level_R10: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> $stable(count));
    // R3: level never exceeds depth
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_ptr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic                     rd_en,
    input  logic [$clog2(DEPTH)-1:0] rd_ptr,
    input  logic                     bypass,
    output logic [WIDTH-1:0]         rd_data,
    output logic                     rd_valid
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= bypass ? wr_data : mem[rd_ptr];
        end
    end

    // R11: pass-through on empty returns the word pushed in that cycle
    assert_bypass_data_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bypass) |=> (rd_valid && rd_data == $past(wr_data)));

endmodule

// File: rtl/fifo_flags.sv
module fifo_flags
    import fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic                       cfg_wr,
    input  logic                       cfg_use_off,
    input  logic [$clog2(DEPTH)-1:0]   cfg_af_off,
    input  logic [$clog2(DEPTH)-1:0]   cfg_ae_off,
    input  logic                       err_clr,
    input  logic                       ovr_evt,
    input  logic                       udr_evt,
    output fifo_status_t               status
);
    localparam int AW  = $clog2(DEPTH);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int QTR = DEPTH / 4;

    logic          use_q;
    logic [AW-1:0] af_q, ae_q;
    logic          ovr_q, udr_q;
    logic [CW-1:0] ae_lim, af_lim;
    logic [CW:0]   af_sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            use_q <= 1'b0;
            af_q  <= '0;
            ae_q  <= '0;
        end else if (cfg_wr) begin
            use_q <= cfg_use_off;
            af_q  <= cfg_af_off;
            ae_q  <= cfg_ae_off;
        end
    end

    // New error wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q <= 1'b0;
            udr_q <= 1'b0;
        end else begin
            ovr_q <= ovr_evt | (ovr_q & ~err_clr);
            udr_q <= udr_evt | (udr_q & ~err_clr);
        end
    end

    always_comb begin
        ae_lim = use_q ? CW'(ae_q) : CW'(QTR);
        af_lim = use_q ? CW'(af_q) : CW'(QTR);
        af_sum = {1'b0, count} + {1'b0, af_lim};
        status.empty     = (count == '0);
        status.not_empty = (count != '0);
        status.full      = (count == CW'(DEPTH));
        status.not_full  = (count != CW'(DEPTH));
        status.ae        = (count < ae_lim);
        status.af        = (af_sum > (CW+1)'(DEPTH));
        status.ovr       = ovr_q;
        status.udr       = udr_q;
    end

    // R6: zero offsets under the select bit silence both almost flags
    assert_zero_off_R6: assert property (@(posedge clk) disable iff (rst)
        (use_q && af_q == '0 && ae_q == '0) |-> !(status.ae || status.af));
    // R7: overrun is sticky without a clear
    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (status.ovr && !err_clr) |=> status.ovr);
    // R8: underrun is sticky without a clear
    assert_udr_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (status.udr && !err_clr) |=> status.udr);
    // R9: a clear with no new event drops both error bits
    assert_err_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !ovr_evt && !udr_evt) |=> !(status.ovr || status.udr));

endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
    import fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  logic [WIDTH-1:0]         push_data,
    input  logic                     pop,
    output logic [WIDTH-1:0]         pop_data,
    output logic                     pop_valid,
    input  logic                     cfg_wr,
    input  logic                     cfg_use_off,
    input  logic [$clog2(DEPTH)-1:0] cfg_af_off,
    input  logic [$clog2(DEPTH)-1:0] cfg_ae_off,
    input  logic                     err_clr,
    output logic [7:0]               status
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          wr_en, rd_en, bypass, ovr_evt, udr_evt;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    fifo_status_t  st;

    fifo_track #(.DEPTH(DEPTH)) u_track (
        .clk(clk), .rst(rst), .push(push), .pop(pop),
        .wr_en(wr_en), .rd_en(rd_en), .bypass(bypass),
        .ovr_evt(ovr_evt), .udr_evt(udr_evt),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count)
    );

    fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .wr_data(push_data), .rd_en(rd_en), .rd_ptr(rd_ptr),
        .bypass(bypass), .rd_data(pop_data), .rd_valid(pop_valid)
    );

    fifo_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst(rst), .count(count), .cfg_wr(cfg_wr),
        .cfg_use_off(cfg_use_off), .cfg_af_off(cfg_af_off),
        .cfg_ae_off(cfg_ae_off), .err_clr(err_clr),
        .ovr_evt(ovr_evt), .udr_evt(udr_evt), .status(st)
    );

    assign status = st;

    // R8: lone pop on empty yields no data and flags underrun
    assert_udr_novalid_R8: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && st.empty) |=> (!pop_valid && st.udr));
    // R2: a pop on a non-empty buffer always returns a word
    assert_pop_valid_R2: assert property (@(posedge clk) disable iff (rst)
        (pop && !st.empty) |=> pop_valid);

endmodule

// File: tb/sim_prog_flag_fifo.sv
module sim_prog_flag_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int WIDTH = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       push = 1'b0, pop = 1'b0, cfg_wr = 1'b0, cfg_use_off = 1'b0, err_clr = 1'b0;
    logic [7:0] push_data = '0;
    logic [3:0] cfg_af_off = '0, cfg_ae_off = '0;
    logic [7:0] pop_data, status;
    logic       pop_valid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_flag_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
        .clk(clk), .rst(rst), .push(push), .push_data(push_data), .pop(pop),
        .pop_data(pop_data), .pop_valid(pop_valid), .cfg_wr(cfg_wr),
        .cfg_use_off(cfg_use_off), .cfg_af_off(cfg_af_off), .cfg_ae_off(cfg_ae_off),
        .err_clr(err_clr), .status(status)
    );

    typedef struct packed {
        logic       pu;
        logic       po;
        logic [7:0] d;
        logic [7:0] st;
        logic       v;
        logic [7:0] q;
    } vec_t;

    // R2 / R4 / R8 / R11: mixed sequence from reset, default thresholds
    localparam vec_t VEC [0:10] = '{
        '{1'b1, 1'b0, 8'hA1, 8'h1A, 1'b0, 8'h00},
        '{1'b1, 1'b0, 8'hB2, 8'h1A, 1'b0, 8'h00},
        '{1'b1, 1'b0, 8'hC3, 8'h1A, 1'b0, 8'h00},
        '{1'b1, 1'b0, 8'hD4, 8'h0A, 1'b0, 8'h00},
        '{1'b0, 1'b1, 8'h00, 8'h1A, 1'b1, 8'hA1},
        '{1'b1, 1'b1, 8'hE5, 8'h1A, 1'b1, 8'hB2},
        '{1'b0, 1'b1, 8'h00, 8'h1A, 1'b1, 8'hC3},
        '{1'b0, 1'b1, 8'h00, 8'h1A, 1'b1, 8'hD4},
        '{1'b0, 1'b1, 8'h00, 8'h19, 1'b1, 8'hE5},
        '{1'b0, 1'b1, 8'h00, 8'h99, 1'b0, 8'h00},
        '{1'b1, 1'b1, 8'h5A, 8'h99, 1'b1, 8'h5A}
    };

    // Expected status from the requirement text (R3..R6)
    function automatic logic [7:0] exp_st(input int c, input bit use_o, input int af,
                                          input int ae, input bit o, input bit u);
        logic a_e, a_f;
        a_e = use_o ? (c < ae) : (c < DEPTH/4);
        a_f = use_o ? (c > DEPTH - af) : (c > DEPTH - DEPTH/4);
        return {u, o, a_f, a_e, c != DEPTH, c == DEPTH, c != 0, c == 0};
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cyc(input logic pu, input logic po, input logic [7:0] d, input logic clr);
        @(negedge clk);
        push = pu; pop = po; push_data = d; err_clr = clr;
        @(negedge clk);
        push = 1'b0; pop = 1'b0; err_clr = 1'b0; cfg_wr = 1'b0;
    endtask

    task automatic cfg(input bit use_o, input logic [3:0] af, input logic [3:0] ae);
        @(negedge clk);
        cfg_use_off = use_o; cfg_af_off = af; cfg_ae_off = ae; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", status, 8'h19);
        chk("R1 pop_valid", pop_valid, 0);

        // Table walk
        for (int i = 0; i < 11; i++) begin
            cyc(VEC[i].pu, VEC[i].po, VEC[i].d, 1'b0);
            chk("R2/R4/R8/R11 status", status, VEC[i].st);
            chk("R2/R8/R11 valid", pop_valid, VEC[i].v);
            if (VEC[i].v) chk("R2/R11 data", pop_data, VEC[i].q);
        end

        // R9 clear
        cyc(1'b0, 1'b0, 8'h00, 1'b1);
        chk("R9 clear", status, exp_st(0, 0, 0, 0, 0, 0));

        // Fill with default thresholds, R3/R4
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1'b1, 1'b0, 8'h40 + 8'(i), 1'b0);
            chk("R3/R4 fill", status, exp_st(i + 1, 0, 0, 0, 0, 0));
        end
        // R7 overrun
        cyc(1'b1, 1'b0, 8'hEE, 1'b0);
        chk("R7 overrun", status, exp_st(DEPTH, 0, 0, 0, 1, 0));
        cyc(1'b0, 1'b0, 8'h00, 1'b0);
        chk("R7 sticky", status, exp_st(DEPTH, 0, 0, 0, 1, 0));
        cyc(1'b0, 1'b0, 8'h00, 1'b1);
        chk("R9 clear ovr", status, exp_st(DEPTH, 0, 0, 0, 0, 0));
        // R10 push+pop on full
        cyc(1'b1, 1'b1, 8'h77, 1'b0);
        chk("R10 status", status, exp_st(DEPTH, 0, 0, 0, 0, 0));
        chk("R10 valid", pop_valid, 1);
        chk("R10 data", pop_data, 8'h40);
        // Drain: R7 dropped word absent, R2 order
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1'b0, 1'b1, 8'h00, 1'b0);
            chk("R2/R7 drain data", pop_data, (i < DEPTH - 1) ? 8'h41 + 8'(i) : 8'h77);
            chk("R4 drain status", status, exp_st(DEPTH - 1 - i, 0, 0, 0, 0, 0));
        end

        // R5 offsets af=2 ae=6
        cfg(1'b1, 4'd2, 4'd6);
        chk("R5 empty with offset", status, exp_st(0, 1, 2, 6, 0, 0));
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1'b1, 1'b0, 8'(i), 1'b0);
            chk("R5 fill", status, exp_st(i + 1, 1, 2, 6, 0, 0));
        end
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1'b0, 1'b1, 8'h00, 1'b0);
            chk("R5 drain", status, exp_st(DEPTH - 1 - i, 1, 2, 6, 0, 0));
        end

        // R6 zero offsets
        cfg(1'b1, 4'd0, 4'd0);
        chk("R6 empty", status, exp_st(0, 1, 0, 0, 0, 0));
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1'b1, 1'b0, 8'(i), 1'b0);
            chk("R6 fill", status, exp_st(i + 1, 1, 0, 0, 0, 0));
        end

        // R12 cfg inputs change without strobe
        @(negedge clk);
        cfg_use_off = 1'b0; cfg_af_off = 4'd9; cfg_ae_off = 4'd9;
        repeat (2) @(negedge clk);
        chk("R12 no strobe", status, exp_st(DEPTH, 1, 0, 0, 0, 0));

        for (int i = 0; i < DEPTH; i++) cyc(1'b0, 1'b1, 8'h00, 1'b0);
        chk("R6 drained", status, exp_st(0, 1, 0, 0, 0, 0));

        // R9 new error wins over simultaneous clear
        cyc(1'b0, 1'b1, 8'h00, 1'b1);
        chk("R9 set wins", status, exp_st(0, 1, 0, 0, 0, 1));
        chk("R8 no data", pop_valid, 0);

        // R1 reset clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 re-reset", status, 8'h19);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule